// File: doc/BRIEF.md
# Serial Port Interrupt Flag Unit

This block keeps the interrupt flags of a serial transceiver and turns them into two interrupt request lines: one for the receive side and one for the transmit side. Three flags are sticky. They are set by single-cycle event pulses from the transceiver: frame sent, data received, and receive overrun. Software can force them high through a write-one-to-set register and drop them through a write-one-to-clear register. A fourth flag reports whether the transmit buffer can take data. It is a copy of a level from the transceiver, so software never has to clear it. An enable mask selects which flags may raise a request.

Software reaches the block through a simple single-cycle register port with fixed byte offsets. A write takes effect at the clock edge on which it is presented. A read returns its word on `rd_data` in the cycle after the request. Outside a read cycle, `rd_data` is zero.

Flag word layout (the same layout is used by the set, clear and enable registers):
- bit 0: frame sent
- bit 1: transmit buffer has room
- bit 2: receive data present
- bit 4: receive overrun

Bit 3 and bits 5 and up are reserved.

Top module: `irqf_unit`

## Requirements
- R1: After reset the flag word, the enable mask, `rd_data`, `irq_rx` and `irq_tx` are all zero.
- R2: Writing to offset 0x44 sets every sticky flag (bits 0, 2, 4) whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: Writing to offset 0x48 clears every sticky flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: A one-cycle pulse on `ev_tx_done`, `ev_rx_avail` or `ev_rx_ovf` sets flag bit 0, 2 or 4 respectively. The flag stays set after the pulse ends.
- R5: If an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: Flag bit 1 equals `tx_room` as sampled at the previous clock edge. Writes to the set and clear registers have no effect on bit 1.
- R7: The enable mask is written and read at offset 0x4C. Only bits 0, 1, 2 and 4 are stored, and the other bits read as zero. The flag word at offset 0x40 is read-only: writes to it are ignored.
- R8: `irq_rx` is a register. It is high one cycle after (flag2 AND enable2) OR (flag4 AND enable4) is true.
- R9: `irq_tx` is a register. It is high one cycle after (flag0 AND enable0) OR (flag1 AND enable1) is true.
- R10: A read returns its data on `rd_data` one cycle after the request. Offsets 0x44, 0x48 and any unmapped offset read as zero. `rd_data` is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, one cycle after the request |
| ev_tx_done | input | 1 | Pulse: frame fully sent |
| tx_room | input | 1 | Level: transmit buffer can accept data |
| ev_rx_avail | input | 1 | Pulse: received word available |
| ev_rx_ovf | input | 1 | Pulse: receive overrun |
| irq_rx | output | 1 | Registered receive interrupt request |
| irq_tx | output | 1 | Registered transmit interrupt request |

## Verification
The request outputs are swept over all 256 combinations of four flag states and four enable bits. The flags are loaded through the set register and the buffer-room level. The sweep separates a wrong group assignment (a receive flag driving `irq_tx`), a missing mask, and an OR that was written as an AND. Directed patterns set and clear partial bit masks to show that zero data bits leave their flags alone. Set and clear writes aimed at the level flag show that it only follows its input. An event pulse that lands in the same cycle as a clear of the same bit shows the priority. Reads of the enable register after an all-ones write, and reads of the write-only and unmapped offsets, expose any reserved bit that was stored or any decode that leaks.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int FLAG_W   = 5;

    localparam int BIT_TXC  = 0;
    localparam int BIT_TXBL = 1;
    localparam int BIT_RXDV = 2;
    localparam int BIT_RXOF = 4;

    localparam int OFF_FLAGS  = 'h40;
    localparam int OFF_SET    = 'h44;
    localparam int OFF_CLEAR  = 'h48;
    localparam int OFF_ENABLE = 'h4C;

    localparam logic [FLAG_W-1:0] MASK_IMPL   = 5'b10111;
    localparam logic [FLAG_W-1:0] MASK_STICKY = 5'b10101;
    localparam logic [FLAG_W-1:0] GROUP_RX    = 5'b10100;
    localparam logic [FLAG_W-1:0] GROUP_TX    = 5'b00011;

    typedef enum logic [1:0] {
        KIND_RSVD,
        KIND_STICKY,
        KIND_LEVEL
    } flag_kind_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_FLAGS,
        REG_SET,
        REG_CLEAR,
        REG_ENABLE
    } reg_sel_e;

    function automatic flag_kind_e kind_of(input int b);
        if (b == BIT_TXBL)
            return KIND_LEVEL;
        else if (MASK_STICKY[b])
            return KIND_STICKY;
        else
            return KIND_RSVD;
    endfunction

endpackage

// File: rtl/irqf_bus_port.sv
module irqf_bus_port
    import irqf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [FLAG_W-1:0] set_mask_o,
    output logic [FLAG_W-1:0] clr_mask_o,
    output logic [FLAG_W-1:0] en_o
);

    reg_sel_e          region;
    logic              rd_req;
    logic              wr_req;
    logic              en_wr;
    logic [FLAG_W-1:0] wr_bits;
    logic [FLAG_W-1:0] en_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        region = REG_NONE;
        if (addr_i == ADDR_W'(OFF_FLAGS))
            region = REG_FLAGS;
        else if (addr_i == ADDR_W'(OFF_SET))
            region = REG_SET;
        else if (addr_i == ADDR_W'(OFF_CLEAR))
            region = REG_CLEAR;
        else if (addr_i == ADDR_W'(OFF_ENABLE))
            region = REG_ENABLE;
    end

    assign rd_req  = sel_i && !wr_i;
    assign wr_req  = sel_i && wr_i;
    assign wr_bits = wdata_i[FLAG_W-1:0] & MASK_IMPL;
    assign en_wr   = wr_req && (region == REG_ENABLE);

    assign set_mask_o = (wr_req && region == REG_SET)   ? wr_bits : '0;
    assign clr_mask_o = (wr_req && region == REG_CLEAR) ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr)
            en_q <= wr_bits;
    end

    always_comb begin
        rd_word = '0;
        unique case (region)
            REG_FLAGS:  rd_word = DATA_W'(flags_i);
            REG_ENABLE: rd_word = DATA_W'(en_q);
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_req ? rd_word : '0;
    end

    assign rdata_o = rdata_q;
    assign en_o    = en_q;

    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> (rdata_o == '0));

    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));

endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] hw_evt_i,
    input  logic              tx_level_i,
    input  logic [FLAG_W-1:0] set_mask_i,
    input  logic [FLAG_W-1:0] clr_mask_i,
    output logic [FLAG_W-1:0] flags_o
);

    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        if (kind_of(b) == KIND_STICKY) begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else
                    bit_q <= hw_evt_i[b] | set_mask_i[b] | (bit_q & ~clr_mask_i[b]);
            end
            assign flags_o[b] = bit_q;
        end else if (kind_of(b) == KIND_LEVEL) begin : g_level
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else
                    bit_q <= tx_level_i;
            end
            assign flags_o[b] = bit_q;
        end else begin : g_rsvd
            assign flags_o[b] = 1'b0;
        end
    end

    p_hw_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt_i != '0) |=> ((flags_o & $past(hw_evt_i)) == $past(hw_evt_i)));

    p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask_i & MASK_STICKY) != '0)
        |=> ((flags_o & $past(set_mask_i & MASK_STICKY)) == $past(set_mask_i & MASK_STICKY)));

    p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((clr_mask_i & MASK_STICKY) != '0) && ((hw_evt_i & clr_mask_i) == '0)
         && ((set_mask_i & clr_mask_i) == '0))
        |=> ((flags_o & $past(clr_mask_i & MASK_STICKY)) == '0));

    p_level_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flags_o[BIT_TXBL] == $past(tx_level_i)));

endmodule

// File: rtl/irqf_req_gen.sv
module irqf_req_gen
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [FLAG_W-1:0] en_i,
    output logic              irq_rx_o,
    output logic              irq_tx_o
);

    logic [FLAG_W-1:0] armed;
    logic              rx_q;
    logic              tx_q;

    assign armed = flags_i & en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
        end else begin
            rx_q <= |(armed & GROUP_RX);
            tx_q <= |(armed & GROUP_TX);
        end
    end

    assign irq_rx_o = rx_q;
    assign irq_tx_o = tx_q;

    p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_rx_o == |($past(flags_i & en_i) & GROUP_RX)));

    p_irq_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_tx_o == |($past(flags_i & en_i) & GROUP_TX)));

endmodule

// File: rtl/irqf_unit.sv
module irqf_unit
    import irqf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_tx_done,
    input  logic              tx_room,
    input  logic              ev_rx_avail,
    input  logic              ev_rx_ovf,
    output logic              irq_rx,
    output logic              irq_tx
);

    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] set_mask;
    logic [FLAG_W-1:0] clr_mask;
    logic [FLAG_W-1:0] en_mask;
    logic [FLAG_W-1:0] hw_evt;

    always_comb begin
        hw_evt           = '0;
        hw_evt[BIT_TXC]  = ev_tx_done;
        hw_evt[BIT_RXDV] = ev_rx_avail;
        hw_evt[BIT_RXOF] = ev_rx_ovf;
    end

    irqf_bus_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (reg_sel),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (wr_data),
        .flags_i    (flags),
        .rdata_o    (rd_data),
        .set_mask_o (set_mask),
        .clr_mask_o (clr_mask),
        .en_o       (en_mask)
    );

    irqf_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_evt_i   (hw_evt),
        .tx_level_i (tx_room),
        .set_mask_i (set_mask),
        .clr_mask_i (clr_mask),
        .flags_o    (flags)
    );

    irqf_req_gen u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_i  (flags),
        .en_i     (en_mask),
        .irq_rx_o (irq_rx),
        .irq_tx_o (irq_tx)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq_rx && !irq_tx));

endmodule

// File: tb/irqf_unit_tb.sv
module irqf_unit_tb;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_sel = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          ev_tx_done = 1'b0;
    logic          tx_room = 1'b0;
    logic          ev_rx_avail = 1'b0;
    logic          ev_rx_ovf = 1'b0;
    logic          irq_rx;
    logic          irq_tx;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    irqf_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .ev_tx_done(ev_tx_done), .tx_room(tx_room), .ev_rx_avail(ev_rx_avail),
        .ev_rx_ovf(ev_rx_ovf), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_sel = 1'b0;
        d = rd_data;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_data", rd_data, 0);
        check("R1 irq_rx", {31'b0, irq_rx}, 0);
        check("R1 irq_tx", {31'b0, irq_tx}, 0);
        rst_n = 1'b1;
        bus_read(8'h40, rv); check("R1 flags", rv, 0);
        bus_read(8'h4C, rv); check("R1 enable", rv, 0);

        // R10: write-only and unmapped offsets read zero, idle rd_data zero
        bus_read(8'h44, rv); check("R10 set reads zero", rv, 0);
        bus_read(8'h48, rv); check("R10 clear reads zero", rv, 0);
        bus_read(8'h50, rv); check("R10 unmapped", rv, 0);

        // R7: enable stores only implemented bits
        bus_write(8'h4C, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R10 idle rd_data", rd_data, 0);
        bus_read(8'h4C, rv); check("R7 enable mask", rv, 32'h17);
        bus_write(8'h4C, 32'h0);

        // R2 / R3: partial set and clear
        bus_write(8'h44, 32'h15);
        bus_read(8'h40, rv); check("R2 set all", rv, 32'h15);
        bus_write(8'h48, 32'h04);
        bus_read(8'h40, rv); check("R3 clear bit2", rv, 32'h11);
        bus_write(8'h44, 32'h04);
        bus_write(8'h44, 32'h00);
        bus_read(8'h40, rv); check("R2 zero leaves", rv, 32'h15);
        bus_write(8'h48, 32'h11);
        bus_read(8'h40, rv); check("R3 clear two", rv, 32'h04);
        bus_write(8'h48, 32'h00);
        bus_read(8'h40, rv); check("R3 zero leaves", rv, 32'h04);

        // R7: flag word is read-only
        bus_write(8'h40, 32'h11);
        bus_read(8'h40, rv); check("R7 flags read-only", rv, 32'h04);
        bus_write(8'h48, 32'h17);

        // R6: level flag ignores set/clear, follows input
        bus_write(8'h44, 32'h02);
        bus_read(8'h40, rv); check("R6 set ignored", rv, 0);
        @(negedge clk); tx_room = 1'b1;
        bus_read(8'h40, rv); check("R6 follows level", rv, 32'h02);
        bus_write(8'h48, 32'h02);
        bus_read(8'h40, rv); check("R6 clear ignored", rv, 32'h02);
        @(negedge clk); tx_room = 1'b0;
        bus_read(8'h40, rv); check("R6 drops with level", rv, 0);

        // R4: event pulses are sticky
        @(negedge clk); ev_tx_done = 1'b1;
        @(negedge clk); ev_tx_done = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(8'h40, rv); check("R4 tx_done sticky", rv, 32'h01);
        @(negedge clk); ev_rx_avail = 1'b1;
        @(negedge clk); ev_rx_avail = 1'b0;
        bus_read(8'h40, rv); check("R4 rx_avail sticky", rv, 32'h05);
        @(negedge clk); ev_rx_ovf = 1'b1;
        @(negedge clk); ev_rx_ovf = 1'b0;
        bus_read(8'h40, rv); check("R4 rx_ovf sticky", rv, 32'h15);
        bus_write(8'h48, 32'h17);
        bus_read(8'h40, rv); check("R3 clear all", rv, 0);

        // R5: event beats clear in the same cycle
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h48; wr_data = 32'h14;
        ev_rx_avail = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; ev_rx_avail = 1'b0;
        bus_read(8'h40, rv); check("R5 set wins", rv, 32'h04);
        bus_write(8'h48, 32'h17);

        // R8 / R9: sweep flag states x enable bits
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                logic [4:0] fl;
                logic [4:0] en;
                logic exp_rx;
                logic exp_tx;
                fl = {p[3], 1'b0, p[2], p[1], p[0]};
                en = {e[3], 1'b0, e[2], e[1], e[0]};
                exp_rx = (fl[2] & en[2]) | (fl[4] & en[4]);
                exp_tx = (fl[0] & en[0]) | (fl[1] & en[1]);
                bus_write(8'h48, 32'h17);
                tx_room = fl[1];
                bus_write(8'h44, {27'b0, fl & 5'b10101});
                bus_write(8'h4C, {27'b0, en});
                @(negedge clk);
                check($sformatf("R8 irq_rx p=%0d e=%0d", p, e), {31'b0, irq_rx}, {31'b0, exp_rx});
                check($sformatf("R9 irq_tx p=%0d e=%0d", p, e), {31'b0, irq_tx}, {31'b0, exp_tx});
            end
        end

        finished = 1'b1;
        finish_run();
    end

endmodule